// File: doc/BRIEF.md
# I2C Bus Hang Guard

This block watches the two wires of an I2C target port, both already synchronized to the system clock. It issues a single-cycle reset pulse to the I2C target logic when the bus looks stuck. A line counts as stuck when it stays low for a fixed time while the other line does not move. The threshold sits near 14 ms and is derived from the clock frequency. The threshold is never stretched to allow for long clock stretching by another bus device, so any device that holds SCL low past the limit triggers the reset.

Shortly after reset is released, the block samples the two pin levels once as a strap. SDA low with SCL high selects standalone operation. That choice is held until the next reset, and in standalone operation the guard stays silent. Resetting the rest of the chip is not part of this block. All pins are plain level signals with no handshake.

Top module: `i2c_hang_guard`

## Requirements
- R1: With SDA held steady, SCL sampled low on LIMIT consecutive clock edges gives exactly one pulse on `bus_reset_o`. The pulse is visible in the cycle after the LIMIT-th low edge. LIMIT = CLK_HZ*TIMEOUT_US/1e6 clock cycles.
- R2: The same holds for SDA sampled low for LIMIT consecutive edges while SCL stays steady.
- R3: Any change of the other line restarts the count. The edge that sees the change does not count. The pulse therefore appears LIMIT+1 edges after the change, and a line low for any time never fires while the other line toggles at least every LIMIT edges.
- R4: Each pulse lasts one clock cycle. After a pulse the guard does not fire again while the line stays low. It re-arms once that line has been sampled high.
- R5: A line low for fewer than LIMIT edges, followed by a return high, gives no pulse.
- R6: SETTLE_CYCLES edges after reset release, `standalone_o` is set if SDA is low and SCL is high. It keeps that value, whatever the pins do, until the next reset.
- R7: While `standalone_o` is 1, `bus_reset_o` stays 0 for any line activity.
- R8: During reset, and before the strap has been sampled, `bus_reset_o` and `standalone_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| bus_reset_o | output | 1 | One-cycle reset pulse for the I2C target logic |
| standalone_o | output | 1 | Latched standalone strap; 1 disables the guard |

## Verification
The hardest situation to reach is a restart caused by the other line. One line has to sit low while the other toggles, and the bench must know exactly which edge saw the last toggle. The bench keeps SCL low and flips SDA every ten cycles for well over LIMIT cycles, which must give no pulse. It records the cycle of the final flip and checks that the pulse lands exactly LIMIT+1 edges later. Standalone operation can only be entered through a reset with strapped pins. The bench therefore resets with SDA low and SCL high, then drives lines stuck low and changes the pins to confirm that the flag and the silence both hold.

// File: rtl/hang_guard_pkg.sv
package hang_guard_pkg;

  // index of each wire within the two-bit bus vector
  typedef enum int {
    WIRE_SCL = 0,
    WIRE_SDA = 1
  } wire_idx_e;

  // number of clock cycles in a time span given in microseconds
  function automatic int span_cycles(input int clk_hz, input int span_us);
    longint prod;
    prod = longint'(clk_hz) * longint'(span_us);
    return int'(prod / 64'sd1_000_000);
  endfunction

endpackage

// File: rtl/line_hold_timer.sv
module line_hold_timer #(
  parameter int LIMIT = 700_000,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic own_i,
  input  logic other_i,
  output logic fire_o
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          other_q;
  logic          armed_q;
  logic          fire_q;
  logic [CW-1:0] cnt_q;
  logic          other_moved;

  assign other_moved = (other_i != other_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      other_q <= 1'b1;
      armed_q <= 1'b1;
      fire_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      other_q <= other_i;
      fire_q  <= 1'b0;
      if (!en_i || own_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (!armed_q || other_moved) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        fire_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fire_o = fire_q;

  // R4
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fire_q |=> !fire_q);

  // R1
  fire_on_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(fire_q) |-> !$past(own_i));

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && other_moved) |=> (cnt_q == '0) && !fire_q);

  // R4
  no_refire_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire_q && !own_i) |=> !armed_q);

endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int SETTLE = 4,
  parameter int SW     = $clog2(SETTLE + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic done_o,
  output logic standalone_o
);

  localparam logic [SW-1:0] LAST = SW'(SETTLE - 1);

  logic [SW-1:0] wait_q;
  logic          done_q;
  logic          alone_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wait_q  <= '0;
      done_q  <= 1'b0;
      alone_q <= 1'b0;
    end else if (!done_q) begin
      if (wait_q == LAST) begin
        done_q  <= 1'b1;
        alone_q <= scl_i & ~sda_i;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

  assign done_o       = done_q;
  assign standalone_o = alone_q;

  // R6
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |=> $stable(alone_q) && done_q);

  // R8
  strap_early_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_q |-> !alone_q);

endmodule

// File: rtl/i2c_hang_guard.sv
module i2c_hang_guard
  import hang_guard_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int TIMEOUT_US    = 14_000,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_reset_o,
  output logic standalone_o
);

  localparam int LIMIT = span_cycles(CLK_HZ, TIMEOUT_US);
  localparam int CW    = $clog2(LIMIT + 1);

  logic [1:0] wires;
  logic [1:0] fire;
  logic       strap_done;
  logic       alone;
  logic       guard_en;

  assign wires[WIRE_SCL] = scl_i;
  assign wires[WIRE_SDA] = sda_i;

  strap_latch #(.SETTLE(SETTLE_CYCLES)) u_strap (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .done_o       (strap_done),
    .standalone_o (alone)
  );

  assign guard_en = strap_done & ~alone;

  for (genvar g = 0; g < 2; g++) begin : g_wire
    line_hold_timer #(.LIMIT(LIMIT), .CW(CW)) u_timer (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (guard_en),
      .own_i   (wires[g]),
      .other_i (wires[1-g]),
      .fire_o  (fire[g])
    );
  end

  assign bus_reset_o  = |fire;
  assign standalone_o = alone;

  // R7
  silent_alone_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    standalone_o |-> !bus_reset_o);

  // R8
  silent_early_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !strap_done |-> !bus_reset_o && !standalone_o);

endmodule

// File: tb/test_i2c_hang_guard.sv
module test_i2c_hang_guard;

  localparam int LIM = 40;
  localparam int SET = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic bus_reset;
  logic standalone;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  int last_pulse = 0;
  int wide = 0;
  logic prev_pulse = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_hang_guard #(
    .CLK_HZ(1_000_000), .TIMEOUT_US(LIM), .SETTLE_CYCLES(SET)
  ) i_i2c_hang_guard (
    .clk_i(clk), .rst_i(rst), .scl_i(scl), .sda_i(sda),
    .bus_reset_o(bus_reset), .standalone_o(standalone)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && bus_reset) begin
      pulses <= pulses + 1;
      last_pulse <= cyc;
      if (prev_pulse) wide <= wide + 1;
    end
    prev_pulse <= bus_reset;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic s_cl, input logic s_da);
    @(negedge clk);
    rst = 1'b1; scl = s_cl; sda = s_da;
    wait_cyc(3);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1, 1'b0);
    scl = 1'b0;
    check("R8 reset pulse", int'(bus_reset), 0);
    wait_cyc(SET - 1);
    check("R8 early flag", int'(standalone), 0);
    check("R8 early pulse", pulses, 0);
    do_reset(1'b1, 1'b1);
    wait_cyc(SET + 2);
    check("R6 idle strap", int'(standalone), 0);
  endtask

  task automatic t_scl_stuck();
    int p0, mark;
    p0 = pulses; mark = cyc;
    scl = 1'b0;
    wait_cyc(LIM + 5);
    check("R1 scl count", pulses - p0, 1);
    check("R1 scl timing", last_pulse - mark, LIM);
    wait_cyc(2 * LIM);
    check("R4 no refire", pulses - p0, 1);
    check("R4 width", wide, 0);
    scl = 1'b1;
    wait_cyc(2);
    mark = cyc;
    scl = 1'b0;
    wait_cyc(LIM + 3);
    check("R4 rearm", pulses - p0, 2);
    check("R4 rearm timing", last_pulse - mark, LIM);
    scl = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_sda_stuck();
    int p0, mark;
    p0 = pulses; mark = cyc;
    sda = 1'b0;
    wait_cyc(LIM + 5);
    check("R2 sda count", pulses - p0, 1);
    check("R2 sda timing", last_pulse - mark, LIM);
    sda = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_short_low();
    int p0;
    p0 = pulses;
    scl = 1'b0;
    wait_cyc(LIM - 1);
    scl = 1'b1;
    wait_cyc(LIM + 5);
    check("R5 short scl", pulses - p0, 0);
    sda = 1'b0;
    wait_cyc(LIM - 1);
    sda = 1'b1;
    wait_cyc(LIM + 5);
    check("R5 short sda", pulses - p0, 0);
  endtask

  task automatic t_other_toggle();
    int p0, mark;
    p0 = pulses;
    scl = 1'b0;
    mark = 0;
    for (int k = 0; k < 8; k++) begin
      wait_cyc(10);
      sda = ~sda;
      mark = cyc;
    end
    check("R3 no fire while toggling", pulses - p0, 0);
    wait_cyc(LIM + 5);
    check("R3 restart count", pulses - p0, 1);
    check("R3 restart timing", last_pulse - mark, LIM + 1);
    scl = 1'b1; sda = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_standalone();
    int p0;
    do_reset(1'b1, 1'b0);
    wait_cyc(SET + 2);
    check("R6 strap set", int'(standalone), 1);
    p0 = pulses;
    wait_cyc(3 * LIM);
    check("R7 sda stuck silent", pulses - p0, 0);
    scl = 1'b0; sda = 1'b1;
    wait_cyc(3 * LIM);
    check("R6 strap held", int'(standalone), 1);
    check("R7 scl stuck silent", pulses - p0, 0);
    do_reset(1'b1, 1'b1);
    wait_cyc(SET + 2);
    check("R6 strap cleared", int'(standalone), 0);
  endtask

  initial begin
    t_reset_state();
    t_scl_stuck();
    t_sda_stuck();
    t_short_low();
    t_other_toggle();
    t_standalone();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule